// File: doc/BRIEF.md
# Serial Password Programming-Mode Detector

This block watches three slow lines driven by an external programming station: a serial data line, a serial clock line and a load strobe. All three are brought into the system clock domain, and each rising edge of the serial clock moves one data bit into an internal byte register. When the station pulls the strobe from high to low, the collected byte is copied into a compare register. The strobe is not honoured while the master reset is asserted or while the power-up reset is still held low. If the copied byte equals a password fixed by parameter, the block enters programming mode. It then raises a system reset request for a fixed number of cycles and holds the watchdog disable high.

Software ends programming mode by writing a configuration word with the end bit set. That write clears the compare register and drops the mode. It also pulses a one-cycle watchdog reload and raises the reset request again for the same fixed length, so the processor restarts.

Top module: `prog_entry_detect`

## Requirements
- R1: After reset, progMode, sysRstReq, wdogDisable and wdogReload are all low.
- R2: Bits move in on rising edges of serClk, most significant bit first. Falling edges of serClk shift nothing. After eight rising edges, the last eight data values, in arrival order from bit 7 down to bit 0, form the byte that the next strobe fall loads.
- R3: Only a high-to-low transition of strobe loads the compare register. A rising edge or a held high level does not load it.
- R4: A strobe fall that occurs while masterRst is high is ignored.
- R5: A strobe fall that occurs while powerUpRstN is low is ignored.
- R6: When a loaded byte equals PASSWORD, progMode goes high and sysRstReq is high for exactly RST_CYCLES consecutive cycles.
- R7: A loaded byte that differs from PASSWORD leaves progMode and sysRstReq unchanged.
- R8: wdogDisable is high exactly while programming mode is active.
- R9: In programming mode, a write with cfgWrEn high and bit END_BIT (default bit 0) of cfgWrData set does four things. It drops progMode and clears the compare register. It pulses wdogReload for exactly one cycle. It raises sysRstReq for exactly RST_CYCLES cycles.
- R10: An end-bit write while programming mode is inactive has no effect. No reset pulse and no reload pulse occur.
- R11: A write with bit END_BIT of cfgWrData clear does not leave programming mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| serClk | input | 1 | Asynchronous serial clock from the programming station |
| serData | input | 1 | Asynchronous serial password data |
| strobe | input | 1 | Asynchronous load strobe; a falling edge loads the compare register |
| masterRst | input | 1 | Master reset active (high); gates the strobe |
| powerUpRstN | input | 1 | Power-up reset line state; low gates the strobe |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | CFG_WIDTH | Configuration write data; bit END_BIT ends programming mode |
| progMode | output | 1 | Programming mode active |
| sysRstReq | output | 1 | Timed system reset request |
| wdogDisable | output | 1 | Watchdog disable |
| wdogReload | output | 1 | One-cycle pulse that reloads the watchdog to its default timeout |

## Verification
The hardest case to reach is a strobe fall that arrives while a reset gate is active and that carries a valid password. It must leave no trace after the gate is released. The shift register still holds the correct byte at that point, so a later falling edge would enter the mode. The stimulus shifts the true password, drops the strobe with masterRst high, and drops it again with powerUpRstN low. After each attempt it releases the gate and checks that the mode stays low and that the reset pulse count does not change. Only then does a clean strobe fall show that the same byte does enter the mode. A bit-reversed password checks the shift order.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic serRise;
    logic strbFall;
  } pfdEvt_t;

  typedef struct packed {
    logic loadCmp;
    logic clearCmp;
  } pfdCtl_t;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] syncPrev
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], asyncIn[b]};
    end
    assign syncOut[b]  = chain[STAGES-1];
    assign syncPrev[b] = chain[STAGES];
  end
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int                PW_WIDTH    = 8,
  parameter logic [PW_WIDTH-1:0] PASSWORD  = 8'hA5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serClk,
  input  logic    serData,
  input  logic    strobe,
  input  pfdCtl_t ctl,
  output pfdEvt_t evt,
  output logic    cmpMatch
);
  localparam int LINES = 3;
  logic [LINES-1:0] nowS, prevS;
  logic [PW_WIDTH-1:0] shiftReg, cmpReg;

  pfd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({strobe, serData, serClk}),
    .syncOut(nowS), .syncPrev(prevS)
  );

  always_comb begin
    evt.serRise  = nowS[0] & ~prevS[0];
    evt.strbFall = ~nowS[2] & prevS[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      cmpReg   <= '0;
    end else begin
      if (evt.serRise) shiftReg <= {shiftReg[PW_WIDTH-2:0], nowS[1]};
      if (ctl.clearCmp)     cmpReg <= '0;
      else if (ctl.loadCmp) cmpReg <= shiftReg;
    end
  end

  assign cmpMatch = (cmpReg == PASSWORD);
endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
#(
  parameter int RST_CYCLES = 384000,
  parameter int CFG_WIDTH  = 8,
  parameter int END_BIT    = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pfdEvt_t              evt,
  input  logic                 cmpMatch,
  input  logic                 masterRst,
  input  logic                 powerUpRstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_WIDTH-1:0] cfgWrData,
  output pfdCtl_t              ctl,
  output logic                 progMode,
  output logic                 sysRstReq,
  output logic                 wdogReload
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] rstCnt;
  logic checkPend, strbGate, endReq;

  always_comb begin
    strbGate     = masterRst | ~powerUpRstN;
    endReq       = cfgWrEn & cfgWrData[END_BIT];
    ctl.loadCmp  = evt.strbFall & ~strbGate;
    ctl.clearCmp = progMode & endReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      progMode   <= 1'b0;
      checkPend  <= 1'b0;
      rstCnt     <= '0;
      wdogReload <= 1'b0;
    end else begin
      checkPend  <= ctl.loadCmp;
      wdogReload <= 1'b0;
      if (rstCnt != '0) rstCnt <= rstCnt - 1'b1;
      if (!progMode && checkPend && cmpMatch) begin
        progMode <= 1'b1;
        rstCnt   <= CNT_LOAD;
      end else if (progMode && endReq) begin
        progMode   <= 1'b0;
        rstCnt     <= CNT_LOAD;
        wdogReload <= 1'b1;
      end
    end
  end

  assign sysRstReq = (rstCnt != '0);
endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect
  import pfd_pkg::*;
#(
  parameter int                  PW_WIDTH    = 8,
  parameter logic [PW_WIDTH-1:0] PASSWORD    = 8'hA5,
  parameter int                  RST_CYCLES  = 384000,
  parameter int                  CFG_WIDTH   = 8,
  parameter int                  END_BIT     = 0,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 strobe,
  input  logic                 masterRst,
  input  logic                 powerUpRstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_WIDTH-1:0] cfgWrData,
  output logic                 progMode,
  output logic                 sysRstReq,
  output logic                 wdogDisable,
  output logic                 wdogReload
);
  pfdEvt_t evt;
  pfdCtl_t ctl;
  logic    cmpMatch;

  pfd_datapath #(.PW_WIDTH(PW_WIDTH), .PASSWORD(PASSWORD), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .strobe(strobe),
    .ctl(ctl), .evt(evt), .cmpMatch(cmpMatch)
  );

  pfd_control #(.RST_CYCLES(RST_CYCLES), .CFG_WIDTH(CFG_WIDTH), .END_BIT(END_BIT)) ctl_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cmpMatch(cmpMatch),
    .masterRst(masterRst), .powerUpRstN(powerUpRstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ctl(ctl), .progMode(progMode), .sysRstReq(sysRstReq), .wdogReload(wdogReload)
  );

  assign wdogDisable = progMode;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic clk,
  input logic rst_n,
  input logic masterRst,
  input logic powerUpRstN,
  input logic progMode,
  input logic sysRstReq,
  input logic wdogReload
);
  a_r6_entry_raises_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(progMode) |-> sysRstReq);

  a_r6_reset_only_on_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysRstReq) |-> ($rose(progMode) || $fell(progMode)));

  a_r9_exit_pulses_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(progMode) |-> wdogReload);

  a_r9_reload_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdogReload |=> !wdogReload);

  a_r10_reload_only_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wdogReload |-> $fell(progMode));

  a_r4_master_reset_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(masterRst) && masterRst && !progMode) |=> !progMode);

  a_r5_por_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(powerUpRstN) && !powerUpRstN && !progMode) |=> !progMode);
endmodule

bind prog_entry_detect pfd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .masterRst(masterRst), .powerUpRstN(powerUpRstN),
  .progMode(progMode), .sysRstReq(sysRstReq), .wdogReload(wdogReload)
);

// File: tb/prog_entry_detect_tb_top.sv
module prog_entry_detect_tb_top;
  localparam int          RSTC = 12;
  localparam logic [7:0]  PW   = 8'h6B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, strobe = 1'b0;
  logic masterRst = 1'b0, powerUpRstN = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic progMode, sysRstReq, wdogDisable, wdogReload;

  always #2 clk = ~clk;

  prog_entry_detect #(.PASSWORD(PW), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .strobe(strobe),
    .masterRst(masterRst), .powerUpRstN(powerUpRstN), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .progMode(progMode), .sysRstReq(sysRstReq),
    .wdogDisable(wdogDisable), .wdogReload(wdogReload)
  );

  typedef struct {
    string req;
    int    sel;   // 0 mode, 1 rstReq, 2 wdogDisable, 3 pulse count, 4 last pulse length, 5 reload cycles
    int    exp;
  } item_t;
  item_t q[$];

  int applied = 0, fails = 0;
  int run = 0, pulses = 0, lastLen = 0, reloadCyc = 0;
  bit done = 1'b0;

  // monitor: samples 1 ns after each rising edge, then pops expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (sysRstReq) run++;
        else if (run > 0) begin pulses++; lastLen = run; run = 0; end
        if (wdogReload) reloadCyc++;
      end
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.sel)
          0: act = int'(progMode);
          1: act = int'(sysRstReq);
          2: act = int'(wdogDisable);
          3: act = pulses;
          4: act = lastLen;
          default: act = reloadCyc;
        endcase
        applied++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input string req, input int sel, input int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      serData = b[i];
      waitN(4); serClk = 1'b1;
      waitN(4); serClk = 1'b0;
      waitN(4);
    end
  endtask

  task automatic strobePulse();
    strobe = 1'b1; waitN(6);
    strobe = 1'b0; waitN(6);
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWrData = d; cfgWrEn = 1'b1; waitN(1);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    waitN(5);
    rst_n = 1'b1;
    waitN(3);
    expect_v("R1 mode", 0, 0); expect_v("R1 rst", 1, 0); expect_v("R1 wd", 2, 0);
    expect_v("R1 reload", 5, 0);
    waitN(2);

    // R2/R7: bit-reversed password does not match
    sendByte(8'hD6); strobePulse(); waitN(30);
    expect_v("R7 mismatch mode", 0, 0); expect_v("R7 mismatch pulses", 3, 0);
    expect_v("R2 reversed order rejected", 0, 0);
    waitN(2);

    // R3: rising edge and held high do not load
    sendByte(PW); strobe = 1'b1; waitN(30);
    expect_v("R3 rise no load", 0, 0);
    waitN(2);
    strobe = 1'b0; waitN(6);
    expect_v("R2 msb-first match enters", 0, 1);
    expect_v("R8 wd high in mode", 2, 1);
    waitN(30);
    expect_v("R6 pulse count", 3, 1); expect_v("R6 pulse length", 4, RSTC);
    expect_v("R6 rst dropped", 1, 0);
    waitN(2);

    // R11: end bit clear
    cfgWrite(8'hFE); waitN(30);
    expect_v("R11 stays in mode", 0, 1); expect_v("R11 no pulse", 3, 1);
    waitN(2);

    // R9: exit
    cfgWrite(8'h01); waitN(30);
    expect_v("R9 mode dropped", 0, 0); expect_v("R8 wd low", 2, 0);
    expect_v("R9 pulse count", 3, 2); expect_v("R9 pulse length", 4, RSTC);
    expect_v("R9 reload one cycle", 5, 1);
    waitN(2);

    // R10: end write while idle
    cfgWrite(8'h01); waitN(30);
    expect_v("R10 no pulse", 3, 2); expect_v("R10 no reload", 5, 1);
    expect_v("R10 mode low", 0, 0);
    waitN(2);

    // R4: master reset gates strobe
    masterRst = 1'b1; sendByte(PW); strobePulse(); masterRst = 1'b0; waitN(30);
    expect_v("R4 gated mode", 0, 0); expect_v("R4 gated pulses", 3, 2);
    waitN(2);

    // R5: power-up reset gates strobe
    powerUpRstN = 1'b0; strobePulse(); powerUpRstN = 1'b1; waitN(30);
    expect_v("R5 gated mode", 0, 0); expect_v("R5 gated pulses", 3, 2);
    waitN(2);

    // clean strobe now enters with the same byte
    strobePulse(); waitN(30);
    expect_v("R4 R5 ungated entry", 0, 1); expect_v("R6 second entry pulses", 3, 3);
    waitN(2);
    cfgWrite(8'h01); waitN(30);
    expect_v("R9 second exit", 0, 0); expect_v("R9 reload total", 5, 2);
    waitN(4);
    done = 1'b1;
    finishRun();
  end
endmodule